// File: doc/BRIEF.md
# Sticky Character Validity Check Latch

This block watches the characters carried on an address data channel and raises an error flag as soon as a malformed character is seen. A character is well formed when its seven bits (check, B, A, 8, 4, 2, 1) hold an odd number of ones. The flag is sticky. While it is still clear, good characters keep it clear. Once it has been set, later good characters cannot clear it, and only the synchronous system reset does.

Two conditions shape when the flag may set. A window of the cycle is exempt from checking: while the compatibility-mode flag and the phase-A indication are both high, a bad character is ignored. An operator check-test input forces the flag set at any time, and it wins over a good character that is present in the same cycle. The block also gives a one-cycle strobe for every sampled character that passes the check. Both outputs are registered and appear one clock after the character that caused them.

Top module: `chan_valid_latch`

## Requirements
- R1: While `rst` is high at a clock edge, both `err_o` and `chk_ok_o` are 0 after that edge.
- R2: A character is good when its `CHAR_W` bits hold an odd count of ones. With the default width the bit order is check=bit 6, B=5, A=4, 8=3, 4=2, 2=1, 1=0, but only the count matters.
- R3: A character with even parity, sampled with `chr_vld_i` high outside the exempt window, sets `err_o` at the next clock edge.
- R4: When `chr_vld_i` is low, the value on `chr_i` has no effect on `err_o` or on `chk_ok_o`.
- R5: When `compat_i` and `phase_a_i` are both high, a bad character does not set `err_o`.
- R6: `phase_a_i` alone, or `compat_i` alone, does not open the exempt window, so a bad character still sets `err_o`.
- R7: Once `err_o` is 1 it stays 1 for every input pattern except reset, including strobed good characters.
- R8: `chk_test_i` high sets `err_o` at the next edge, even when a strobed good character is present in the same cycle and even inside the exempt window.
- R9: Reset wins over every set condition in the same cycle and is the only way to clear `err_o`.
- R10: `chk_ok_o` is 1 for exactly the cycle after a strobed good character and 0 otherwise. It is independent of the exempt window and of the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chr_i | input | CHAR_W | Channel character |
| chr_vld_i | input | 1 | Channel character strobe |
| phase_a_i | input | 1 | Cycle is in its first logic-gate phase |
| compat_i | input | 1 | Cycle runs in compatibility mode |
| chk_test_i | input | 1 | Operator check-test force-set |
| err_o | output | 1 | Sticky validity error flag |
| chk_ok_o | output | 1 | One-cycle strobe for a good sampled character |

## Verification
The bench builds the block with its default values, `CHAR_W` = 7 and odd parity selected. With only 128 character codes, random stimulus reaches every parity class many times, and it covers every combination of strobe, phase and mode flags in both states of the latch. Directed cases then pin down the collisions: a force-set against a good character, a bad character inside and just outside the exempt window, and a reset against a force-set.

// File: rtl/cvl_pkg.sv
package cvl_pkg;

    // State of the validity trigger
    typedef enum logic [0:0] {
        CVL_CLEAR = 1'b0,   // no error seen since reset
        CVL_SET   = 1'b1    // error captured, held by feedback
    } cvl_state_e;

endpackage

// File: rtl/cvl_parity.sv
// Parity evaluator for one channel character, built as an XOR chain.
module cvl_parity #(
    parameter int CHAR_W     = 7,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic [CHAR_W-1:0] chr_i,
    output logic              good_o
);
    logic [CHAR_W-1:0] fold;

    assign fold[0] = chr_i[0];

    generate
        for (genvar i = 1; i < CHAR_W; i++) begin : g_fold
            assign fold[i] = fold[i-1] ^ chr_i[i];
        end
        if (ODD_PARITY) begin : g_odd
            assign good_o = fold[CHAR_W-1];
        end else begin : g_even
            assign good_o = ~fold[CHAR_W-1];
        end
    endgenerate
endmodule

// File: rtl/cvl_exempt.sv
// Qualifies the sampled character with the exempt-window rule.
module cvl_exempt (
    input  logic chr_vld_i,
    input  logic good_i,
    input  logic phase_a_i,
    input  logic compat_i,
    output logic bad_armed_o,
    output logic good_seen_o
);
    logic in_window;

    always_comb begin
        in_window   = compat_i & phase_a_i;
        bad_armed_o = chr_vld_i & ~good_i & ~in_window;
        good_seen_o = chr_vld_i & good_i;
    end
endmodule

// File: rtl/cvl_fsm.sv
// Two-state trigger: the set path has priority over the clear condition.
module cvl_fsm
    import cvl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bad_armed_i,
    input  logic good_seen_i,
    input  logic force_i,
    output logic err_o
);
    cvl_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CVL_CLEAR: begin
                if (force_i || bad_armed_i)
                    state_d = CVL_SET;      // CLEAR -> SET
                else if (good_seen_i)
                    state_d = CVL_CLEAR;    // held clear by a good character
            end
            CVL_SET: begin
                state_d = CVL_SET;          // feedback hold
            end
            default: state_d = CVL_CLEAR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CVL_CLEAR;
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CVL_CLEAR: err_o = 1'b0;
            CVL_SET:   err_o = 1'b1;
            default:   err_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/chan_valid_latch.sv
module chan_valid_latch #(
    parameter int CHAR_W     = 7,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] chr_i,
    input  logic              chr_vld_i,
    input  logic              phase_a_i,
    input  logic              compat_i,
    input  logic              chk_test_i,
    output logic              err_o,
    output logic              chk_ok_o
);
    logic good;
    logic bad_armed;
    logic good_seen;
    logic ok_q;

    cvl_parity #(.CHAR_W(CHAR_W), .ODD_PARITY(ODD_PARITY)) u_par (
        .chr_i  (chr_i),
        .good_o (good)
    );

    cvl_exempt u_ex (
        .chr_vld_i   (chr_vld_i),
        .good_i      (good),
        .phase_a_i   (phase_a_i),
        .compat_i    (compat_i),
        .bad_armed_o (bad_armed),
        .good_seen_o (good_seen)
    );

    cvl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .bad_armed_i (bad_armed),
        .good_seen_i (good_seen),
        .force_i     (chk_test_i),
        .err_o       (err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) ok_q <= 1'b0;
        else     ok_q <= good_seen;
    end

    assign chk_ok_o = ok_q;
endmodule

// File: rtl/chan_valid_latch_chk.sv
module chan_valid_latch_chk #(
    parameter int CHAR_W     = 7,
    parameter bit ODD_PARITY = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [CHAR_W-1:0] chr_i,
    input logic              chr_vld_i,
    input logic              phase_a_i,
    input logic              compat_i,
    input logic              chk_test_i,
    input logic              err_o,
    input logic              chk_ok_o
);
    logic par_good;
    assign par_good = ODD_PARITY ? (^chr_i) : ~(^chr_i);

    // R1, R9: reset clears both outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!err_o && !chk_ok_o));

    // R3: bad strobed character outside the window sets the flag
    a_r3_bad_sets: assert property (@(posedge clk) disable iff (rst)
        (chr_vld_i && !par_good && !(compat_i && phase_a_i)) |=> err_o);

    // R5: inside the window, with no force, a clear flag stays clear
    a_r5_window_masks: assert property (@(posedge clk) disable iff (rst)
        (!err_o && compat_i && phase_a_i && !chk_test_i) |=> !err_o);

    // R7: sticky hold
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R8: force-set wins
    a_r8_force_sets: assert property (@(posedge clk) disable iff (rst)
        chk_test_i |=> err_o);

    // R10: good strobe follows a strobed good character
    a_r10_ok_strobe: assert property (@(posedge clk) disable iff (rst)
        (chr_vld_i && par_good) |=> chk_ok_o);

    a_r10_ok_quiet: assert property (@(posedge clk) disable iff (rst)
        !(chr_vld_i && par_good) |=> !chk_ok_o);
endmodule

bind chan_valid_latch chan_valid_latch_chk #(
    .CHAR_W(CHAR_W), .ODD_PARITY(ODD_PARITY)
) u_chk (.*);

// File: tb/chan_valid_latch_tb_top.sv
module chan_valid_latch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] chr;
    logic         vld, pa, cm, ct;
    logic         err, ok;

    int checks = 0;
    int fails  = 0;
    bit exp_err, exp_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_valid_latch #(.CHAR_W(W), .ODD_PARITY(1'b1)) dut_i (
        .clk(clk), .rst(rst), .chr_i(chr), .chr_vld_i(vld),
        .phase_a_i(pa), .compat_i(cm), .chk_test_i(ct),
        .err_o(err), .chk_ok_o(ok)
    );

    function automatic bit is_good(input logic [W-1:0] c);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(c[i]);
        return (n % 2) == 1;
    endfunction

    function automatic bit next_err(input bit cur, input bit r, input bit v,
                                    input logic [W-1:0] c, input bit a,
                                    input bit m, input bit t);
        if (r) return 1'b0;
        if (cur || t) return 1'b1;
        if (v && !is_good(c) && !(a && m)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit next_ok(input bit r, input bit v, input logic [W-1:0] c);
        return !r && v && is_good(c);
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, then check at the next falling edge
    task automatic step(input string req_e, input string req_o,
                        input bit r, input bit v, input logic [W-1:0] c,
                        input bit a, input bit m, input bit t);
        rst = r; vld = v; chr = c; pa = a; cm = m; ct = t;
        exp_err = next_err(exp_err, r, v, c, a, m, t);
        exp_ok  = next_ok(r, v, c);
        @(negedge clk);
        check(req_e, err, exp_err);
        check(req_o, ok, exp_ok);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1; vld = 0; chr = '0; pa = 0; cm = 0; ct = 0;
        exp_err = 0; exp_ok = 0;
        @(negedge clk);
        // R1: reset state
        step("R1", "R1", 1, 1, 7'b0000011, 0, 0, 1);
        // R2, R10: good character (one bit set) keeps the flag clear and strobes ok
        step("R2", "R10", 0, 1, 7'b0000001, 0, 0, 0);
        step("R2", "R10", 0, 1, 7'b1111111, 0, 0, 0);
        // R4: a bad character without the strobe is ignored
        step("R4", "R4", 0, 0, 7'b0000011, 0, 0, 0);
        // R5: window masks a bad character
        step("R5", "R10", 0, 1, 7'b0000000, 1, 1, 0);
        // R6: phase A alone does not mask
        step("R6", "R10", 0, 1, 7'b0000110, 1, 0, 0);
        // R7: a good character cannot clear
        step("R7", "R10", 0, 1, 7'b0100000, 0, 0, 0);
        step("R7", "R4", 0, 0, 7'b0100000, 0, 0, 0);
        // R9: reset against a force in the same cycle
        step("R9", "R9", 1, 1, 7'b0000001, 0, 0, 1);
        // R6: compat alone does not mask
        step("R6", "R10", 0, 1, 7'b1100000, 0, 1, 0);
        step("R9", "R1", 1, 0, '0, 0, 0, 0);
        // R8: force wins over a good character, also inside the window
        step("R8", "R10", 0, 1, 7'b0000100, 1, 1, 1);
        step("R9", "R1", 1, 0, '0, 0, 0, 0);
        step("R8", "R10", 0, 1, 7'b0010000, 0, 0, 1);
        step("R7", "R10", 0, 1, 7'b0010000, 0, 0, 0);
        step("R9", "R1", 1, 0, '0, 0, 0, 0);
        // R3: bad character sets the flag
        step("R3", "R10", 0, 1, 7'b1000001, 0, 0, 0);
        step("R9", "R1", 1, 0, '0, 0, 0, 0);

        // Random phase: mostly clear-state traffic, occasional resets and forces
        for (int k = 0; k < 3000; k++) begin
            bit r = ($urandom % 40) == 0;
            bit v = ($urandom % 4) != 0;
            logic [W-1:0] c = W'($urandom);
            bit a = ($urandom % 2) == 1;
            bit m = ($urandom % 2) == 1;
            bit t = ($urandom % 60) == 0;
            // bias toward good characters so the clear state lasts
            if (($urandom % 4) != 0 && !is_good(c)) c[0] = ~c[0];
            step(exp_err ? "R7" : "R3", "R10", r, v, c, a, m, t);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule